// File: doc/BRIEF.md
# Keyboard Digit Entry Accumulator

This block sits behind a PS/2 keyboard receiver and turns the digit keys a user types into one binary number. Each scan code arrives with a one-cycle ready strobe. A decode stage recognises the ten digit make codes of scan-code set 2 and gives each one its numeric value. An accumulate stage then folds the successive digits into a running total in decimal positional order, so typing 2, 5, 4 builds 254. The multiply by ten uses a shift-and-add.

Pressing Enter publishes the running total on the output, raises a completion strobe for one clock and starts the next number from zero. A key release is sent as a break prefix followed by a repeat of the key's code. The block drops the code that follows the prefix, so a key release never counts as a second press. If the typed value does not fit in the output width, the total stops at the largest value it can hold and an overflow flag is reported with that entry.

Top module: `kbd_digit_accum`

## Requirements
- R1: While reset (rst_n low) is held and on its release, total is 0, entry_done is 0 and overflow is 0.
- R2: With scan_valid high, the codes 0x45, 0x16, 0x1E, 0x26, 0x25, 0x2E, 0x36, 0x3D, 0x3E and 0x46 are taken as the digits 0, 1, 2, 3, 4, 5, 6, 7, 8 and 9.
- R3: Each accepted digit d updates the running value v to v*10 + d, so a sequence of digits followed by Enter produces the decimal number the sequence spells.
- R4: An accepted Enter code 0x5A copies the running value and its overflow state to total and overflow at that clock edge. It pulses entry_done high for exactly one cycle and clears the running value and its overflow state to 0.
- R5: The scan code accepted right after a break prefix 0xF0 is discarded, whatever its value, including a digit, Enter or another 0xF0.
- R6: Any code other than the ten digit codes, 0x5A and 0xF0 has no effect.
- R7: With the default 8-bit width, when an update would make the running value exceed 255, the running value becomes 255 and stays there for the rest of the entry. The following Enter then reports total 255 and overflow 1. An entry that stays within 255 reports overflow 0.
- R8: A scan_code value presented while scan_valid is low has no effect.
- R9: total and overflow change only at an Enter. They hold their values while further digits are being typed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz in the intended use) |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_code | input | 8 | Scan code from the keyboard receiver |
| scan_valid | input | 1 | One-cycle strobe marking scan_code as a new code |
| total | output | TOTAL_W | Number published at the last Enter |
| entry_done | output | 1 | One-cycle pulse after an Enter is accepted |
| overflow | output | 1 | Set when the published number was clipped to the maximum |

## Verification
The checker assumes that scan_valid is never high on two consecutive cycles, because a keyboard receiver delivers codes far apart. Its one-cycle entry_done property depends on that. The stimulus keeps an idle cycle after every code. Break sequences are sent as a real keyboard sends them: prefix, then a repeat of the key's code. Each code is held stable for the whole of its strobe cycle.

// File: rtl/kde_pkg.sv
package kde_pkg;

   localparam logic [7:0] KDE_ENTER = 8'h5A;
   localparam logic [7:0] KDE_BREAK = 8'hF0;
   localparam int         KDE_NDIG  = 10;

   function automatic logic [7:0] kde_digit_code(input int idx);
      logic [7:0] c;
      case (idx)
         0: c = 8'h45;
         1: c = 8'h16;
         2: c = 8'h1E;
         3: c = 8'h26;
         4: c = 8'h25;
         5: c = 8'h2E;
         6: c = 8'h36;
         7: c = 8'h3D;
         8: c = 8'h3E;
         default: c = 8'h46;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/kde_decode.sv
module kde_decode
   import kde_pkg::*;
#(
   parameter int CODE_W  = 8,
   parameter int DIGIT_W = 4
) (
   input  logic [CODE_W-1:0]  code,
   output logic               is_digit,
   output logic [DIGIT_W-1:0] digit,
   output logic               is_enter,
   output logic               is_break
);

   logic [KDE_NDIG-1:0] hit;

   for (genvar gi = 0; gi < KDE_NDIG; gi++) begin : g_cmp
      assign hit[gi] = (code == CODE_W'(kde_digit_code(gi)));
   end

   always_comb begin
      digit = '0;
      for (int i = 0; i < KDE_NDIG; i++) begin
         if (hit[i]) digit = DIGIT_W'(i);
      end
   end

   assign is_digit = |hit;
   assign is_enter = (code == CODE_W'(KDE_ENTER));
   assign is_break = (code == CODE_W'(KDE_BREAK));

endmodule

// File: rtl/kde_filter.sv
module kde_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic is_break,
   output logic accept
);

   logic skip_r;

   assign accept = valid & ~skip_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         skip_r <= 1'b0;
      end else if (valid) begin
         if (skip_r) skip_r <= 1'b0;
         else        skip_r <= is_break;
      end
   end

endmodule

// File: rtl/kde_accum.sv
module kde_accum #(
   parameter int TOTAL_W = 8,
   parameter int DIGIT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               digit_stb,
   input  logic [DIGIT_W-1:0] digit,
   input  logic               enter_stb,
   output logic [TOTAL_W-1:0] total,
   output logic               entry_done,
   output logic               overflow
);

   localparam int               EXT_W = TOTAL_W + 4;
   localparam logic [TOTAL_W-1:0] MAXV = {TOTAL_W{1'b1}};

   logic [TOTAL_W-1:0] acc_r;
   logic               ovf_r;
   logic [EXT_W-1:0]   acc_ext;
   logic [EXT_W-1:0]   next_ext;
   logic               too_big;

   assign acc_ext  = EXT_W'(acc_r);
   assign next_ext = (acc_ext << 3) + (acc_ext << 1) + EXT_W'(digit);
   assign too_big  = ovf_r | (next_ext > EXT_W'(MAXV));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_r      <= '0;
         ovf_r      <= 1'b0;
         total      <= '0;
         entry_done <= 1'b0;
         overflow   <= 1'b0;
      end else begin
         entry_done <= enter_stb;
         if (enter_stb) begin
            total    <= acc_r;
            overflow <= ovf_r;
            acc_r    <= '0;
            ovf_r    <= 1'b0;
         end else if (digit_stb) begin
            if (too_big) begin
               acc_r <= MAXV;
               ovf_r <= 1'b1;
            end else begin
               acc_r <= next_ext[TOTAL_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/kbd_digit_accum.sv
module kbd_digit_accum #(
   parameter int TOTAL_W = 8,
   parameter int CODE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CODE_W-1:0]  scan_code,
   input  logic               scan_valid,
   output logic [TOTAL_W-1:0] total,
   output logic               entry_done,
   output logic               overflow
);

   localparam int DIGIT_W = 4;

   if (TOTAL_W < 4) begin : g_bad_total
      $error("kbd_digit_accum: TOTAL_W must be at least 4");
   end
   if (CODE_W != 8) begin : g_bad_code
      $error("kbd_digit_accum: CODE_W must be 8");
   end

   logic               is_digit;
   logic               is_enter;
   logic               is_break;
   logic [DIGIT_W-1:0] digit;
   logic               accept;

   kde_decode #(.CODE_W(CODE_W), .DIGIT_W(DIGIT_W)) u_dec (
      .code     (scan_code),
      .is_digit (is_digit),
      .digit    (digit),
      .is_enter (is_enter),
      .is_break (is_break)
   );

   kde_filter u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (scan_valid),
      .is_break (is_break),
      .accept   (accept)
   );

   kde_accum #(.TOTAL_W(TOTAL_W), .DIGIT_W(DIGIT_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .digit_stb  (accept & is_digit),
      .digit      (digit),
      .enter_stb  (accept & is_enter),
      .total      (total),
      .entry_done (entry_done),
      .overflow   (overflow)
   );

endmodule

// File: rtl/kde_chk.sv
module kde_chk #(
   parameter int TOTAL_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [7:0]         scan_code,
   input logic               scan_valid,
   input logic [TOTAL_W-1:0] total,
   input logic               entry_done,
   input logic               overflow
);

   // R4
   done_needs_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |-> ($past(scan_valid) && $past(scan_code) == kde_pkg::KDE_ENTER));

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |=> !entry_done);

   // R9
   total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !entry_done |-> ($stable(total) && $stable(overflow)));

   // R7
   ovf_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (total == {TOTAL_W{1'b1}}));

   // R8
   idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(scan_valid) |-> !entry_done);

endmodule

bind kbd_digit_accum kde_chk #(.TOTAL_W(TOTAL_W)) u_kde_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scan_code  (scan_code),
   .scan_valid (scan_valid),
   .total      (total),
   .entry_done (entry_done),
   .overflow   (overflow)
);

// File: tb/kbd_digit_accum_test.sv
module kbd_digit_accum_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] scan_code = 8'h00;
   logic       scan_valid = 1'b0;
   logic [7:0] total;
   logic       entry_done;
   logic       overflow;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   kbd_digit_accum uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_code  (scan_code),
      .scan_valid (scan_valid),
      .total      (total),
      .entry_done (entry_done),
      .overflow   (overflow)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [7:0] code_of(input int d);
      case (d)
         0: return 8'h45;
         1: return 8'h16;
         2: return 8'h1E;
         3: return 8'h26;
         4: return 8'h25;
         5: return 8'h2E;
         6: return 8'h36;
         7: return 8'h3D;
         8: return 8'h3E;
         default: return 8'h46;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c);
      @(negedge clk);
      scan_code  = c;
      scan_valid = 1'b1;
      @(negedge clk);
      scan_valid = 1'b0;
      scan_code  = 8'h00;
   endtask

   task automatic press(input int d);
      send(code_of(d));
      send(8'hF0);
      send(code_of(d));
   endtask

   task automatic type_num(input int n);
      int digs[5];
      int cnt = 0;
      int v = n;
      do begin
         digs[cnt] = v % 10;
         v = v / 10;
         cnt++;
      end while (v != 0 && cnt < 5);
      for (int i = cnt - 1; i >= 0; i--) press(digs[i]);
   endtask

   task automatic enter_check(input string req, input int exp_tot, input bit exp_ovf);
      send(8'h5A);
      chk(entry_done == 1'b1, req, int'(entry_done), 1);
      chk(total == 8'(exp_tot), req, int'(total), exp_tot);
      chk(overflow == exp_ovf, req, int'(overflow), int'(exp_ovf));
      @(negedge clk);
      chk(entry_done == 1'b0, "R4", int'(entry_done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: values during reset
      chk(total == 8'd0, "R1", int'(total), 0);
      chk(entry_done == 1'b0, "R1", int'(entry_done), 0);
      chk(overflow == 1'b0, "R1", int'(overflow), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(total == 8'd0 && !entry_done && !overflow, "R1", int'(total), 0);

      // R2: every digit alone
      for (int d = 0; d < 10; d++) begin
         press(d);
         enter_check("R2", d, 1'b0);
      end

      // R3: full sweep 0..255
      for (int n = 0; n < 256; n++) begin
         type_num(n);
         enter_check("R3", n, 1'b0);
      end
      press(2); press(5); press(4);
      enter_check("R3", 254, 1'b0);

      // R4: empty entry after a number yields 0
      enter_check("R4", 0, 1'b0);

      // R7: overflow sweep
      for (int n = 256; n < 1400; n += 7) begin
         type_num(n);
         enter_check("R7", 255, 1'b1);
      end
      press(2); press(5); press(6);
      enter_check("R7", 255, 1'b1);
      press(2); press(5); press(5);
      enter_check("R7", 255, 1'b0);
      press(0); press(2); press(5); press(5);
      enter_check("R7", 255, 1'b0);
      press(9); press(9); press(9); press(0);
      enter_check("R7", 255, 1'b1);
      press(7);
      enter_check("R7", 7, 1'b0);

      // R5: break prefix swallows digit, Enter and another prefix
      press(4);
      send(8'hF0); send(code_of(9));
      send(8'hF0); send(8'h5A);
      chk(entry_done == 1'b0, "R5", int'(entry_done), 0);
      @(negedge clk);
      chk(entry_done == 1'b0, "R5", int'(entry_done), 0);
      send(8'hF0); send(8'hF0);
      press(2);
      enter_check("R5", 42, 1'b0);

      // R6: other codes ignored
      press(1);
      send(8'h1C); send(8'h29); send(8'h00); send(8'hFF); send(8'h70); send(8'hE0);
      press(3);
      send(8'h66);
      enter_check("R6", 13, 1'b0);

      // R8: code without strobe ignored
      press(6);
      @(negedge clk);
      scan_code = code_of(8);
      repeat (3) @(negedge clk);
      scan_code = 8'h5A;
      repeat (2) @(negedge clk);
      chk(entry_done == 1'b0, "R8", int'(entry_done), 0);
      scan_code = 8'h00;
      enter_check("R8", 6, 1'b0);

      // R9: outputs hold while typing
      press(3); press(1);
      chk(total == 8'd6 && overflow == 1'b0, "R9", int'(total), 6);
      press(9); press(9);
      chk(total == 8'd6 && overflow == 1'b0, "R9", int'(total), 6);
      enter_check("R9", 255, 1'b1);
      press(1);
      repeat (5) @(negedge clk);
      chk(total == 8'd255 && overflow == 1'b1, "R9", int'(total), 255);
      enter_check("R9", 1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule